// File: doc/BRIEF.md
# Sponge hash absorb-squeeze controller

This block drives a fixed-length sponge hash over a byte stream. It owns the sponge state register and steps it through absorption and squeezing. The permutation core sits outside and is reached through a start/done handshake. On each call the controller presents the whole state together with a round count. The core later returns the permuted state with a one-cycle done strobe.

A run begins with a start pulse that carries the message length in bytes. The state is cleared to zero, with a configurable constant written into its last byte; a constant of zero leaves the state fully clear. Input bytes are accepted one per handshake and XORed into the leading rate bytes of the state. The permutation runs after every full rate block. The final block is partial, or empty when the length is a multiple of the rate or zero. That block is closed by XORing 0x01 at the position just after its last data byte, and then one more permutation runs.

The digest then leaves through a ready-gated byte port, one squeeze-rate chunk at a time, taken from the front of the state. A permutation runs between chunks but not after the last one. A one-cycle done pulse follows acceptance of the last digest byte. The digest length must be a whole multiple of the squeeze rate.

Top module: `sponge_hash_ctrl`

## Requirements
- R1: While reset is held and directly after it, in_ready, out_valid, perm_start and done are all 0.
- R2: At the start of a run the state is all zero except byte STATE_BYTES-1, which holds LAST_CONST. Byte i of the state is bits [8i+7:8i] of perm_state_out and of perm_state_in.
- R3: Input byte k of the message (counting from 0) is XORed into state byte k mod RATE_BYTES. After every RATE_BYTES accepted bytes the permutation is started with the updated state.
- R4: After the last data byte, 0x01 is XORed into state byte (msg_len mod RATE_BYTES) and one permutation follows. A zero length, or a length that is a multiple of RATE_BYTES, therefore yields a padding-only block with 0x01 in byte 0.
- R5: in_ready is high only during absorption and exactly msg_len bytes are accepted. Bytes offered after the message are ignored. No digest byte is offered before all message bytes are accepted.
- R6: Every permutation call presents perm_rounds equal to HASH_ROUNDS.
- R7: The digest is DIGEST_BYTES bytes, sent as chunks of state bytes 0 to SQZ_BYTES-1 in ascending order. One permutation runs between consecutive chunks and none after the last. A run therefore makes msg_len/RATE_BYTES + DIGEST_BYTES/SQZ_BYTES calls in total, using integer division.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: done is high for exactly one cycle: the cycle after the last digest byte is accepted. The block is then idle and accepts the next start.
- R10: perm_start is a one-cycle pulse. No further call starts and no byte moves on either port until perm_done returns the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled when idle |
| msg_len | input | LEN_W | Message length in bytes, sampled with start |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| out_valid | output | 1 | Digest byte offered |
| out_data | output | 8 | Digest byte |
| out_ready | input | 1 | Downstream accepts the digest byte |
| done | output | 1 | One-cycle pulse after the last digest byte |
| perm_start | output | 1 | Request one permutation of perm_state_out |
| perm_rounds | output | RND_W | Round count for the permutation |
| perm_state_out | output | STATE_BYTES*8 | Current state presented to the core |
| perm_done | input | 1 | Core returns the permuted state this cycle |
| perm_state_in | input | STATE_BYTES*8 | Permuted state from the core |

## Verification
in_ready and out_valid depend only on registered state. A byte handshake therefore takes effect on the edge it is sampled, and the XOR shows up in perm_state_out on that same edge. perm_start rises in the cycle after the byte that fills a block, or after the padding cycle. The returned state is loaded on the edge that samples perm_done, and the port that resumes is valid in the following cycle. done comes exactly one cycle after the last digest handshake. The bench drives and samples on the falling edge. It compares the presented state at every perm_start against a behavioural sponge model, and each accepted digest byte against that model's squeeze queue. It also checks done on every cycle against a flag set by the previous cycle's final accept.

// File: rtl/sponge_hash_pkg.sv
package sponge_hash_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ABSORB,
    PH_PERM_REQ,
    PH_PERM_WAIT,
    PH_SQUEEZE,
    PH_FIN
  } phase_t;

  localparam logic [7:0] PAD_BYTE = 8'h01;

  // permutations spent while absorbing: every full block plus the closing padded block
  function automatic int unsigned absorb_perm_count(input int unsigned len,
                                                    input int unsigned rate);
    return len / rate + 1;
  endfunction

  // permutations spent while squeezing: one between each pair of chunks
  function automatic int unsigned squeeze_perm_count(input int unsigned digest,
                                                     input int unsigned sqz);
    return digest / sqz - 1;
  endfunction

endpackage

// File: rtl/sponge_hash_state.sv
module sponge_hash_state #(
  parameter int unsigned STATE_BYTES = 48,
  parameter logic [7:0]  LAST_CONST  = 8'h80,
  localparam int unsigned IDX_W = $clog2(STATE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init_en,
  input  logic                        xor_en,
  input  logic [IDX_W-1:0]            xor_idx,
  input  logic [7:0]                  xor_byte,
  input  logic                        load_en,
  input  logic [STATE_BYTES-1:0][7:0] load_val,
  output logic [STATE_BYTES-1:0][7:0] st
);

  function automatic logic [STATE_BYTES-1:0][7:0] fresh_state();
    logic [STATE_BYTES-1:0][7:0] v;
    v = '0;
    v[STATE_BYTES-1] = LAST_CONST;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (init_en) begin
      st <= fresh_state();
    end else if (load_en) begin
      st <= load_val;
    end else if (xor_en) begin
      st[xor_idx] <= st[xor_idx] ^ xor_byte;
    end
  end

endmodule

// File: rtl/sponge_hash_seq.sv
module sponge_hash_seq
  import sponge_hash_pkg::*;
#(
  parameter int unsigned STATE_BYTES  = 48,
  parameter int unsigned RATE_BYTES   = 16,
  parameter int unsigned SQZ_BYTES    = 16,
  parameter int unsigned DIGEST_BYTES = 32,
  parameter int unsigned LEN_W        = 16,
  localparam int unsigned IDX_W = $clog2(STATE_BYTES),
  localparam int unsigned DIG_W = $clog2(DIGEST_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             perm_done,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             in_ready,
  output logic             out_valid,
  output logic             perm_start,
  output logic             done,
  output logic             init_ev,
  output logic             absorb_fire,
  output logic             pad_fire,
  output logic             load_ev,
  output logic             squeeze_fire,
  output logic             last_byte
);

  phase_t           ret_ph;
  logic [LEN_W-1:0] rem;
  logic [DIG_W-1:0] dig_rem;
  logic             block_end;
  logic             chunk_end;

  always_comb begin
    in_ready     = (phase == PH_ABSORB) && (rem != '0);
    absorb_fire  = in_ready && in_valid;
    pad_fire     = (phase == PH_ABSORB) && (rem == '0);
    out_valid    = (phase == PH_SQUEEZE);
    squeeze_fire = out_valid && out_ready;
    perm_start   = (phase == PH_PERM_REQ);
    done         = (phase == PH_FIN);
    init_ev      = (phase == PH_IDLE) && start;
    load_ev      = (phase == PH_PERM_WAIT) && perm_done;
    block_end    = absorb_fire && (idx == IDX_W'(RATE_BYTES - 1));
    chunk_end    = squeeze_fire && (idx == IDX_W'(SQZ_BYTES - 1));
    last_byte    = squeeze_fire && (dig_rem == DIG_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      ret_ph  <= PH_IDLE;
      idx     <= '0;
      rem     <= '0;
      dig_rem <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            rem     <= msg_len;
            idx     <= '0;
            dig_rem <= DIG_W'(DIGEST_BYTES);
            phase   <= PH_ABSORB;
          end
        end
        PH_ABSORB: begin
          if (pad_fire) begin
            idx    <= '0;
            ret_ph <= PH_SQUEEZE;
            phase  <= PH_PERM_REQ;
          end else if (absorb_fire) begin
            rem <= rem - 1'b1;
            if (block_end) begin
              idx    <= '0;
              ret_ph <= PH_ABSORB;
              phase  <= PH_PERM_REQ;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_PERM_REQ: phase <= PH_PERM_WAIT;
        PH_PERM_WAIT: begin
          if (perm_done) phase <= ret_ph;
        end
        PH_SQUEEZE: begin
          if (squeeze_fire) begin
            dig_rem <= dig_rem - 1'b1;
            if (last_byte) begin
              phase <= PH_FIN;
            end else if (chunk_end) begin
              idx    <= '0;
              ret_ph <= PH_SQUEEZE;
              phase  <= PH_PERM_REQ;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        PH_FIN: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sponge_hash_ctrl.sv
module sponge_hash_ctrl
  import sponge_hash_pkg::*;
#(
  parameter int unsigned STATE_BYTES  = 48,
  parameter int unsigned RATE_BYTES   = 16,
  parameter int unsigned SQZ_BYTES    = 16,
  parameter int unsigned DIGEST_BYTES = 32,
  parameter int unsigned LEN_W        = 16,
  parameter int unsigned RND_W        = 8,
  parameter logic [RND_W-1:0] HASH_ROUNDS = RND_W'(68),
  parameter logic [7:0]  LAST_CONST   = 8'h80,
  localparam int unsigned IDX_W = $clog2(STATE_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LEN_W-1:0]         msg_len,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [7:0]               out_data,
  input  logic                     out_ready,
  output logic                     done,
  output logic                     perm_start,
  output logic [RND_W-1:0]         perm_rounds,
  output logic [STATE_BYTES*8-1:0] perm_state_out,
  input  logic                     perm_done,
  input  logic [STATE_BYTES*8-1:0] perm_state_in
);

  phase_t                      phase;
  logic [IDX_W-1:0]            idx;
  logic                        init_ev;
  logic                        absorb_fire;
  logic                        pad_fire;
  logic                        load_ev;
  logic                        squeeze_fire;
  logic                        last_byte;
  logic [7:0]                  mix_byte;
  logic [STATE_BYTES-1:0][7:0] st;

  sponge_hash_seq #(
    .STATE_BYTES (STATE_BYTES),
    .RATE_BYTES  (RATE_BYTES),
    .SQZ_BYTES   (SQZ_BYTES),
    .DIGEST_BYTES(DIGEST_BYTES),
    .LEN_W       (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .msg_len     (msg_len),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .perm_done   (perm_done),
    .phase       (phase),
    .idx         (idx),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .perm_start  (perm_start),
    .done        (done),
    .init_ev     (init_ev),
    .absorb_fire (absorb_fire),
    .pad_fire    (pad_fire),
    .load_ev     (load_ev),
    .squeeze_fire(squeeze_fire),
    .last_byte   (last_byte)
  );

  assign mix_byte = absorb_fire ? in_data : PAD_BYTE;

  sponge_hash_state #(
    .STATE_BYTES(STATE_BYTES),
    .LAST_CONST (LAST_CONST)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_en (init_ev),
    .xor_en  (absorb_fire || pad_fire),
    .xor_idx (idx),
    .xor_byte(mix_byte),
    .load_en (load_ev),
    .load_val(perm_state_in),
    .st      (st)
  );

  assign out_data       = st[idx];
  assign perm_state_out = st;
  assign perm_rounds    = HASH_ROUNDS;

endmodule

// File: rtl/sponge_hash_chk.sv
module sponge_hash_chk
  import sponge_hash_pkg::*;
#(
  parameter int unsigned RATE_BYTES   = 16,
  parameter int unsigned SQZ_BYTES    = 16,
  parameter int unsigned DIGEST_BYTES = 32,
  parameter int unsigned LEN_W        = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_ev,
  input logic [LEN_W-1:0] msg_len,
  input logic             in_ready,
  input logic             absorb_fire,
  input logic             pad_fire,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             squeeze_fire,
  input logic             perm_start,
  input logic             perm_done,
  input logic             load_ev,
  input logic             done
);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] in_cnt;
  int unsigned      perm_cnt;
  logic             waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= '0;
      in_cnt   <= '0;
      perm_cnt <= 0;
      waiting  <= 1'b0;
    end else begin
      if (init_ev) begin
        len_q    <= msg_len;
        in_cnt   <= '0;
        perm_cnt <= 0;
      end else begin
        if (absorb_fire) in_cnt <= in_cnt + 1'b1;
        if (perm_start)  perm_cnt <= perm_cnt + 1;
      end
      if (perm_start)   waiting <= 1'b1;
      else if (load_ev) waiting <= 1'b0;
    end
  end

  assert_perm_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perm_start |=> !perm_start);

  assert_quiet_while_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !(in_ready || out_valid || perm_start));

  assert_ports_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_byte_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_fire |-> (in_cnt == len_q));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(squeeze_fire));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_perm_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (perm_cnt == absorb_perm_count(int'(len_q), RATE_BYTES)
                         + squeeze_perm_count(DIGEST_BYTES, SQZ_BYTES)));

  assert_done_not_early_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perm_done |-> !done);

endmodule

bind sponge_hash_ctrl sponge_hash_chk #(
  .RATE_BYTES  (RATE_BYTES),
  .SQZ_BYTES   (SQZ_BYTES),
  .DIGEST_BYTES(DIGEST_BYTES),
  .LEN_W       (LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_ev     (init_ev),
  .msg_len     (msg_len),
  .in_ready    (in_ready),
  .absorb_fire (absorb_fire),
  .pad_fire    (pad_fire),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .squeeze_fire(squeeze_fire),
  .perm_start  (perm_start),
  .perm_done   (perm_done),
  .load_ev     (load_ev),
  .done        (done)
);

// File: tb/tb_sponge_hash_ctrl.sv
`timescale 1ns/1ps
module tb_sponge_hash_ctrl;

  localparam int S      = 48;
  localparam int RATE   = 16;
  localparam int SQZ    = 16;
  localparam int DIG    = 32;
  localparam int LW     = 16;
  localparam int RW     = 8;
  localparam logic [RW-1:0] ROUNDS = 8'd68;
  localparam logic [7:0]    LASTC  = 8'h80;
  localparam int LAT    = 3;

  typedef logic [S-1:0][7:0] st_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] msg_len = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [7:0]    out_data;
  logic          out_ready = 1'b0;
  logic          done;
  logic          perm_start;
  logic [RW-1:0] perm_rounds;
  logic [S*8-1:0] perm_state_out;
  logic          perm_done = 1'b0;
  logic [S*8-1:0] perm_state_in = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  st_t    exp_pre[$];
  byte unsigned exp_dig[$];

  always #2.5 clk = ~clk;

  sponge_hash_ctrl #(
    .STATE_BYTES(S), .RATE_BYTES(RATE), .SQZ_BYTES(SQZ), .DIGEST_BYTES(DIG),
    .LEN_W(LW), .RND_W(RW), .HASH_ROUNDS(ROUNDS), .LAST_CONST(LASTC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .perm_start(perm_start), .perm_rounds(perm_rounds),
    .perm_state_out(perm_state_out), .perm_done(perm_done),
    .perm_state_in(perm_state_in)
  );

  function automatic st_t scramble(st_t s);
    st_t r;
    for (int i = 0; i < S; i++) begin
      logic [7:0] a;
      a = s[(i + 1) % S];
      r[i] = {a[6:0], a[7]} ^ s[(i + 7) % S] ^ 8'((i * 5 + 1) & 255);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // stand-in permutation core: answers LAT falling edges after a request
  initial begin
    forever begin
      @(negedge clk);
      if (perm_start && rst_n) begin
        st_t cap;
        cap = perm_state_out;
        repeat (LAT) @(negedge clk);
        perm_state_in = scramble(cap);
        perm_done = 1'b1;
        @(negedge clk);
        perm_done = 1'b0;
      end
    end
  end

  // behavioural sponge: expected pre-permutation states and digest bytes
  task automatic build_model(input byte unsigned msg[$]);
    st_t s;
    int  pos;
    exp_pre.delete();
    exp_dig.delete();
    s = '0;
    s[S-1] = LASTC;
    pos = 0;
    foreach (msg[k]) begin
      s[pos] = s[pos] ^ msg[k];
      pos++;
      if (pos == RATE) begin
        exp_pre.push_back(s);
        s = scramble(s);
        pos = 0;
      end
    end
    s[pos] = s[pos] ^ 8'h01;
    exp_pre.push_back(s);
    s = scramble(s);
    for (int c = 0; c < DIG / SQZ; c++) begin
      for (int b = 0; b < SQZ; b++) exp_dig.push_back(s[b]);
      if (c != DIG / SQZ - 1) begin
        exp_pre.push_back(s);
        s = scramble(s);
      end
    end
  endtask

  task automatic run_case(int len, int vmode, int rmode, int seed);
    byte unsigned msg[$];
    int  sent;
    bit  last_acc;
    bit  seen_done;
    bit  held;
    logic [7:0] held_data;
    for (int k = 0; k < len; k++) msg.push_back(8'((k * 29 + seed * 13 + 7) & 255));
    build_model(msg);
    @(negedge clk);
    start = 1'b1;
    msg_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    msg_len = LW'(16'hBEEF);
    sent = 0; last_acc = 0; seen_done = 0; held = 0; held_data = '0;
    for (int t = 0; t < 4000 && !seen_done; t++) begin
      if (t != 0) @(negedge clk);
      cyc++;
      if (done || last_acc)
        check(done == last_acc, "R9", "done timing", done, last_acc);
      if (done) begin
        seen_done = 1;
        in_valid = 1'b0;
        out_ready = 1'b0;
      end else begin
        last_acc = 0;
        if (held)
          check(out_valid && out_data == held_data, "R8", "held digest byte",
                {out_valid, out_data}, {1'b1, held_data});
        if (perm_start) begin
          check(perm_rounds == ROUNDS, "R6", "round count", perm_rounds, ROUNDS);
          if (exp_pre.size() == 0) begin
            check(1'b0, "R7", "extra permutation call", 1, 0);
          end else begin
            st_t e;
            e = exp_pre.pop_front();
            n_tests++;
            if (perm_state_out !== e) begin
              n_fail++;
              $display("FAIL R2 R3 R4 state at call: actual %h expected %h", perm_state_out, e);
            end
          end
        end
        if (in_ready && sent == len)
          check(1'b0, "R5", "in_ready after message", sent, len);
        if (out_valid && sent != len)
          check(1'b0, "R5", "digest before absorb end", sent, len);
        if (sent < len) begin
          in_valid = (vmode == 0) || (cyc % 2 == 0);
          in_data  = msg[sent];
        end else begin
          in_valid = 1'b1;
          in_data  = 8'hEE;
        end
        if (in_valid && in_ready) sent++;
        out_ready = (rmode == 0) || (cyc % 3 != 1);
        held = out_valid && !out_ready;
        held_data = out_data;
        if (out_valid && out_ready) begin
          if (exp_dig.size() == 0) begin
            check(1'b0, "R7", "extra digest byte", out_data, 0);
          end else begin
            byte unsigned d;
            d = exp_dig.pop_front();
            check(out_data == d, "R7", "digest byte", out_data, d);
            if (exp_dig.size() == 0) last_acc = 1;
          end
        end
      end
    end
    check(seen_done, "R9", "done reached", seen_done, 1);
    check(exp_pre.size() == 0, "R7", "permutation calls missing", exp_pre.size(), 0);
    check(exp_dig.size() == 0, "R7", "digest bytes missing", exp_dig.size(), 0);
    check(sent == len, "R5", "bytes accepted", sent, len);
    @(negedge clk);
    check(!in_ready && !out_valid && !perm_start && !done, "R9", "idle after run",
          {in_ready, out_valid, perm_start, done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && !perm_start && !done, "R1", "outputs in reset",
          {in_ready, out_valid, perm_start, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready && !out_valid && !perm_start && !done, "R1", "outputs after reset",
          {in_ready, out_valid, perm_start, done}, 0);
    run_case(0,  0, 0, 1);   // R4 empty message: padding-only block
    run_case(5,  1, 0, 2);   // R3 R4 partial block, gapped input
    run_case(16, 0, 1, 3);   // R4 exact rate multiple, back-pressure R8
    run_case(15, 0, 0, 4);   // R4 pad in last rate byte
    run_case(37, 1, 1, 5);   // R3 several blocks, both ports throttled
    run_case(32, 0, 0, 6);   // R3 two full blocks then padding block
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule